// File: doc/BRIEF.md
# Parallel Integer Add-and-Store Execute Unit

This unit runs one dual-operation instruction word in a single execute cycle. Two operations run side by side. An integer addition takes a general register and a word read from internal data memory, and writes the sum to a general register. An integer store writes a third general register to data memory. Each memory operand is an indirect reference through one of eight address registers. Its offset is zero, one, or one of two index registers.

Every source is captured at the start of the cycle, and every write happens at its end. As a result, a store whose source is the add's destination stores the old value. An add whose memory operand is the store's target reads the old word. The unit holds eight general registers, eight address registers, two index registers, a 256-word data memory and an integer status word. Debug outputs expose all of the registers and the status word. The only way to read memory is to add a memory word to a register that holds zero.

Top module: `par_addstore_unit`

## Requirements
- R1: The unit executes a word only when `instr_valid` is 1 at a rising clock edge and `instr[31:25]` equals 7'b1100111. Any other word changes no register, address register or flag, and raises no `done`.
- R2: `done` is 1 for the single cycle that follows the edge at which an accepted word performs its writes. It is 0 after a cycle in which no word is accepted.
- R3: The add writes general register `instr[24:22]` with the 32-bit wrapped sum of general register `instr[21:19]` and the memory word addressed by the src2 field `instr[7:0]`.
- R4: The store writes general register `instr[18:16]` to the memory word addressed by the dst2 field `instr[15:8]`. When that register is also the add's destination, the value stored is the one it held before the add.
- R5: When the src2 and dst2 fields address the same word, the add uses the word as it was before the store. The store's value remains in memory afterwards.
- R6: Each indirect field is laid out as follows. Bits [7:6] select the form: 0 gives address AR+disp, 1 gives AR−disp, 2 gives address AR followed by AR+=disp, and 3 gives address AR followed by AR−=disp. Bits [5:4] select disp: 0 gives 0, 1 gives 1, 2 gives IR0, 3 gives IR1. Bit 3 is ignored. Bits [2:0] pick the address register. The memory address is the low 8 bits of the computed value.
- R7: A post-modifying form writes the updated address register at the end of the cycle. If both fields post-modify the same address register, the dst2 update is the one kept.
- R8: Status bits are laid out as follows: bit 0 C (carry out), bit 1 V (signed overflow), bit 2 Z (zero sum), bit 3 N (sum bit 31). Every executed word sets or clears each of them according to its sum.
- R9: Bit 5 LV is set whenever V is set and is otherwise kept. Bit 4 UF is written 0. Bit 6 LUF is never changed.
- R10: Reset has these effects. All general registers become 0. Address register n becomes 32·n. IR0 becomes 16 and IR1 becomes 3. Memory word a becomes the byte a repeated four times. The status word becomes 0 and `done` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word |
| instr_valid | input | 1 | Instruction word is present this cycle |
| done | output | 1 | One-cycle pulse after an executed word |
| dbg_rf | output | 256 | General registers, Rn at bits [32n+31:32n] |
| dbg_ar | output | 256 | Address registers, ARn at bits [32n+31:32n] |
| dbg_ir0 | output | 32 | Index register IR0 |
| dbg_ir1 | output | 32 | Index register IR1 |
| dbg_st | output | 7 | Status word {LUF, LV, UF, N, Z, V, C} |

## Verification
All results of an accepted word fall due together. The register sum, the address-register updates, the status bits and `done` are all visible after the single edge that samples the word. A memory write is due at that same edge, and it shows up only through the sum of the next executed word. The bench drives each word on a falling edge and holds it across exactly one rising edge. It reads the debug outputs and `done` on the following falling edge. It then checks that `done` has dropped one falling edge later. Store effects are read back through a later word that adds the memory word to R0, which is held at zero.

// File: rtl/par_addstore_unit.sv
module par_addstore_unit #(
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int DEPTH   = 256,
  parameter int IR0_RST = 16,
  parameter int IR1_RST = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        instr,
  input  logic               instr_valid,
  output logic               done,
  output logic [NREG*DW-1:0] dbg_rf,
  output logic [NREG*DW-1:0] dbg_ar,
  output logic [DW-1:0]      dbg_ir0,
  output logic [DW-1:0]      dbg_ir1,
  output logic [6:0]         dbg_st
);
  localparam int AW   = $clog2(DEPTH);
  localparam int RW   = $clog2(NREG);
  localparam int STEP = DEPTH / NREG;

  logic [DW-1:0] rf  [NREG];
  logic [DW-1:0] ar  [NREG];
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ir0, ir1;
  logic [6:0]    st;

  function automatic logic [DW-1:0] pick_disp(input logic [1:0] sel,
                                              input logic [DW-1:0] i0,
                                              input logic [DW-1:0] i1);
    case (sel)
      2'd0:    return '0;
      2'd1:    return DW'(1);
      2'd2:    return i0;
      default: return i1;
    endcase
  endfunction

  wire           hit = instr_valid && (instr[31:25] == 7'b1100111);
  wire [RW-1:0]  d1  = instr[22 +: RW];
  wire [RW-1:0]  s1  = instr[19 +: RW];
  wire [RW-1:0]  s3  = instr[16 +: RW];
  wire [7:0]     f_d = instr[15:8];
  wire [7:0]     f_s = instr[7:0];

  wire [RW-1:0] s_idx = f_s[RW-1:0];
  wire [RW-1:0] d_idx = f_d[RW-1:0];

  wire [DW-1:0] s_base = ar[s_idx];
  wire [DW-1:0] d_base = ar[d_idx];
  wire [DW-1:0] s_disp = pick_disp(f_s[5:4], ir0, ir1);
  wire [DW-1:0] d_disp = pick_disp(f_d[5:4], ir0, ir1);
  wire [DW-1:0] s_up   = s_base + s_disp;
  wire [DW-1:0] s_dn   = s_base - s_disp;
  wire [DW-1:0] d_up   = d_base + d_disp;
  wire [DW-1:0] d_dn   = d_base - d_disp;

  wire [DW-1:0] s_ea  = (f_s[7:6] == 2'd0) ? s_up : (f_s[7:6] == 2'd1) ? s_dn : s_base;
  wire [DW-1:0] d_ea  = (f_d[7:6] == 2'd0) ? d_up : (f_d[7:6] == 2'd1) ? d_dn : d_base;
  wire [DW-1:0] s_new = f_s[6] ? s_dn : s_up;
  wire [DW-1:0] d_new = f_d[6] ? d_dn : d_up;

  wire [AW-1:0] s_addr = s_ea[AW-1:0];
  wire [AW-1:0] d_addr = d_ea[AW-1:0];

  wire [DW-1:0] opa = rf[s1];
  wire [DW-1:0] opb = mem[s_addr];
  wire [DW-1:0] stv = rf[s3];
  wire [DW:0]   sum = {1'b0, opa} + {1'b0, opb};
  wire          ovf = (opa[DW-1] == opb[DW-1]) && (sum[DW-1] != opa[DW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rf[i] <= '0;
        ar[i] <= DW'(i * STEP);
      end
      for (int a = 0; a < DEPTH; a++)
        mem[a] <= {(DW/8){8'(a)}};
      ir0  <= DW'(IR0_RST);
      ir1  <= DW'(IR1_RST);
      st   <= '0;
      done <= 1'b0;
    end else begin
      done <= hit;
      if (hit) begin
        rf[d1]      <= sum[DW-1:0];
        mem[d_addr] <= stv;
        if (f_s[7]) ar[s_idx] <= s_new;
        if (f_d[7]) ar[d_idx] <= d_new;
        st <= {st[6], st[5] | ovf, 1'b0, sum[DW-1], (sum[DW-1:0] == '0), ovf, sum[DW]};
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg_rf[g*DW +: DW] = rf[g];
    assign dbg_ar[g*DW +: DW] = ar[g];
  end
  assign dbg_ir0 = ir0;
  assign dbg_ir1 = ir1;
  assign dbg_st  = st;
endmodule

// File: rtl/par_addstore_chk.sv
module par_addstore_chk #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        instr,
  input logic               instr_valid,
  input logic               done,
  input logic [NREG*DW-1:0] dbg_rf,
  input logic [NREG*DW-1:0] dbg_ar,
  input logic [6:0]         dbg_st
);
  wire take = instr_valid && (instr[31:25] == 7'b1100111);

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> done);
  a_r1_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !done);
  a_r1_idle_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(dbg_rf) && $stable(dbg_ar) && $stable(dbg_st)));
  a_r9_uf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_st[4]);
  a_r9_luf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_st[6]);
  a_r9_lv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_st[5] |=> dbg_st[5]);
  a_r8_v_sets_lv: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_st[1] |-> dbg_st[5]);
endmodule

bind par_addstore_unit par_addstore_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
  .done(done), .dbg_rf(dbg_rf), .dbg_ar(dbg_ar), .dbg_st(dbg_st)
);

// File: tb/tb_par_addstore_unit.sv
`timescale 1ns/1ps
module tb_par_addstore_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  instr = '0;
  logic         instr_valid = 1'b0;
  logic         done;
  logic [255:0] dbg_rf, dbg_ar;
  logic [31:0]  dbg_ir0, dbg_ir1;
  logic [6:0]   dbg_st;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  par_addstore_unit dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
    .done(done), .dbg_rf(dbg_rf), .dbg_ar(dbg_ar),
    .dbg_ir0(dbg_ir0), .dbg_ir1(dbg_ir1), .dbg_st(dbg_st)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] ind(input logic [1:0] kind, input logic [1:0] dsel,
                                     input logic [2:0] arn);
    return {kind, dsel, 1'b0, arn};
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] d1, input logic [2:0] s1,
                                     input logic [2:0] s3, input logic [7:0] fd,
                                     input logic [7:0] fs);
    return {7'b1100111, d1, s1, s3, fd, fs};
  endfunction

  // {instr, reg index, expected reg value, expected status}
  localparam int NV = 7;
  localparam logic [74:0] VEC [NV] = '{
    {mk(3'd1, 3'd0, 3'd0, ind(0,0,0), ind(0,0,4)), 3'd1, 32'h80808080, 8'h08},
    {mk(3'd2, 3'd1, 3'd0, ind(0,0,0), ind(0,0,4)), 3'd2, 32'h01010100, 8'h23},
    {mk(3'd3, 3'd0, 3'd0, ind(0,0,0), ind(0,0,0)), 3'd3, 32'h00000000, 8'h24},
    {mk(3'd1, 3'd1, 3'd1, ind(0,0,5), ind(0,1,7)), 3'd1, 32'h62626261, 8'h23},
    {mk(3'd4, 3'd0, 3'd0, ind(0,0,0), ind(0,0,5)), 3'd4, 32'h80808080, 8'h28},
    {mk(3'd5, 3'd0, 3'd1, ind(0,3,6), ind(0,3,6)), 3'd5, 32'hC3C3C3C3, 8'h28},
    {mk(3'd6, 3'd0, 3'd0, ind(0,0,0), ind(0,3,6)), 3'd6, 32'h62626261, 8'h20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input string req);
    @(negedge clk);
    instr = w;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check({req, " R2 done high"}, 32'(done), 32'd1);
    @(negedge clk);
    check({req, " R2 done low"}, 32'(done), 32'd0);
  endtask

  task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
    check(req, dbg_rf[idx*32 +: 32], exp);
  endtask

  task automatic chk_ar(input string req, input int idx, input logic [31:0] exp);
    check(req, dbg_ar[idx*32 +: 32], exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] snap_rf, snap_ar;
    logic [6:0]   snap_st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 done", 32'(done), 32'd0);
    check("R10 status", 32'(dbg_st), 32'd0);
    check("R10 ir0", dbg_ir0, 32'd16);
    check("R10 ir1", dbg_ir1, 32'd3);
    for (int i = 0; i < 8; i++) begin
      chk_reg("R10 regfile", i, 32'd0);
      chk_ar("R10 addr reg", i, 32'(i * 32));
    end

    // R3 R4 R5 R8 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      run(VEC[v][74:43], "R3 vector");
      chk_reg("R3 R4 R5 sum", int'(VEC[v][42:40]), VEC[v][39:8]);
      check("R8 R9 status", 32'(dbg_st), 32'(VEC[v][6:0]));
    end

    // R6 R7 post-increment by IR0 on AR2, post-decrement by 1 on AR3
    run(mk(3'd7, 3'd0, 3'd0, ind(3,1,3), ind(2,2,2)), "R6");
    chk_reg("R6 post-inc read", 7, 32'h40404040);
    chk_ar("R7 AR2 update", 2, 32'd80);
    chk_ar("R7 AR3 update", 3, 32'd95);
    check("R8 status positive", 32'(dbg_st), 32'h20);

    // R6 pre-decrement by IR0, no register change
    run(mk(3'd7, 3'd0, 3'd0, ind(0,0,0), ind(1,2,1)), "R6");
    chk_reg("R6 minus disp read", 7, 32'h10101010);
    chk_ar("R6 AR1 unchanged", 1, 32'd32);

    // R4 store went to old AR3 (96)
    run(mk(3'd6, 3'd0, 3'd0, ind(0,0,0), ind(0,1,3)), "R4");
    chk_reg("R4 store at old AR address", 6, 32'd0);
    check("R8 zero flag", 32'(dbg_st), 32'h24);

    // R7 both fields post-modify AR4: dst2 wins
    run(mk(3'd7, 3'd0, 3'd0, ind(3,3,4), ind(2,1,4)), "R7");
    chk_reg("R7 shared AR read", 7, 32'h80808080);
    chk_ar("R7 dst2 priority", 4, 32'd125);
    run(mk(3'd5, 3'd0, 3'd0, ind(0,0,0), ind(0,3,4)), "R7");
    chk_reg("R5 store final value", 5, 32'd0);

    // R1 wrong opcode and missing valid are ignored
    snap_rf = dbg_rf;
    snap_ar = dbg_ar;
    snap_st = dbg_st;
    @(negedge clk);
    instr = mk(3'd1, 3'd4, 3'd0, ind(2,1,0), ind(2,1,1)) ^ 32'h0200_0000;
    instr_valid = 1'b1;
    @(negedge clk);
    check("R1 bad opcode no done", 32'(done), 32'd0);
    instr = mk(3'd1, 3'd4, 3'd0, ind(2,1,0), ind(2,1,1));
    instr_valid = 1'b0;
    @(negedge clk);
    check("R1 no valid no done", 32'(done), 32'd0);
    check("R1 regs unchanged", 32'(dbg_rf == snap_rf), 32'd1);
    check("R1 addr regs unchanged", 32'(dbg_ar == snap_ar), 32'd1);
    check("R1 status unchanged", 32'(dbg_st), 32'(snap_st));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule